// File: doc/BRIEF.md
# Pitch-Stepped PCM / Delta Sample Voice

This block is one playback voice of a sample-based sound generator. After a key-on pulse it walks through a region of an external byte-wide sample memory. It starts from a 21-bit start address and covers a 16-bit length. It produces a signed sample scaled by a 7-bit volume. A phase accumulator sets the rate at which bytes are fetched. The accumulator adds a per-clock cycle increment and issues one step each time it crosses 4096. On each step it reloads with the residue plus a 12-bit pitch.

Two sample formats are supported. In PCM mode each step consumes one signed byte. In delta mode each byte supplies two 4-bit codes. Each code adds a fixed signed amount to a saturating 16-bit running value, and code zero adds nothing. Playback can run forward or backward through memory. When the length runs out, the voice either restarts from the start address, which clears the running value, or stops and drops its busy flag.

The memory port is combinational: the voice drives the address of the byte it consumes at a step, and it stores the returned byte at the same clock edge.

Top module: `vox_voice`

## Requirements
- R1: After reset, `busy` is 0 and `sample` is 0.
- R2: A `key_on` pulse makes `busy` 1 at the next edge. The voice loads the phase counter with `pitch`, the position with `start_addr` and the remaining count with `length`. It clears the stored byte and the delta value, so `sample` is 0 right after key-on. A `key_off` pulse clears `busy` at the next edge. When both pulses arrive together, `key_on` wins.
- R3: While busy, the phase counter adds `cyc_inc` at every clock edge. When the sum is at least 4096, exactly one step occurs and the counter becomes sum − 4096 + `pitch`, clamped to 8191. Otherwise the counter becomes the sum.
- R4: In PCM mode (`delta_mode`=0), every step moves the position by one byte. The move is +1 when `reverse`=0 and −1 when `reverse`=1, so the first step after key-on reads `start_addr`±1. `mem_addr` shows the new position during the stepping cycle, and that byte is stored at the edge.
- R5: In delta mode (`delta_mode`=1), a byte supplies two codes, so the position moves on every second step, and the first step after key-on moves it. Going forward, bits [3:0] are used before bits [7:4]. In reverse, bits [7:4] are used first.
- R6: In delta mode, code c adds +2^(c−1) for c in 1..7 and −2^(15−c) for c in 8..15. Code 0 leaves the value unchanged. The value saturates at +32767 and −32768.
- R7: A position move made when the remaining count is already 0 ends the pass, so a pass covers length+1 moves. With `loop_en`=1 the position returns to `start_addr`, the count reloads and the delta value restarts from 0, with the new byte's code applied. With `loop_en`=0 `busy` clears and `sample` becomes 0.
- R8: While busy, `sample` equals `volume` (unsigned) times the signed source: the delta value in delta mode, or the stored byte sign-extended in PCM mode. While not busy, `sample` is 0.
- R9: Position arithmetic wraps modulo 2^21 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_on | input | 1 | Start pulse |
| key_off | input | 1 | Stop pulse |
| pitch | input | 12 | Phase reload added after each step |
| length | input | 16 | Number of position moves per pass, minus one |
| start_addr | input | 21 | First byte position of the pass |
| volume | input | 7 | Unsigned output gain |
| loop_en | input | 1 | Restart at end of pass instead of stopping |
| delta_mode | input | 1 | 1 = two 4-bit delta codes per byte, 0 = 8-bit PCM |
| reverse | input | 1 | 1 = walk memory downward |
| cyc_inc | input | 8 | Phase increment applied at each clock |
| mem_addr | output | 21 | Sample memory byte address (combinational) |
| mem_data | input | 8 | Byte returned for `mem_addr` in the same cycle |
| sample | output | 23 | Signed scaled sample |
| busy | output | 1 | Voice is playing |

## Verification
Key-on, key-off, step and end-of-pass effects on `busy` and `sample` all take effect at the clock edge that sees the input, so they are due one edge after the stimulus. `mem_addr` responds within the same cycle, because the stepping decision is combinational from the counter and `cyc_inc`. The bench drives inputs a fraction of a cycle after the falling edge and samples `mem_addr` just after that. It compares `busy` and `sample` at the next falling edge against a cycle-stepped model of its own. That places every comparison between edges, in the cycle where each result is defined.

// File: rtl/vox_pkg.sv
package vox_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int BPOS_W = 4;

  localparam logic [BPOS_W-1:0] BPOS_START = 4'd4;
  localparam logic [BPOS_W-1:0] BPOS_HALF  = 4'd8;

  typedef enum logic {
    PLAY_PCM   = 1'b0,
    PLAY_DELTA = 1'b1
  } play_mode_e;

  // Bit-position bookkeeping: a byte boundary adds eight, consumption
  // removes one nibble (delta) or a whole byte (PCM).
  function automatic logic [BPOS_W-1:0] bpos_after(
    input logic [BPOS_W-1:0] bp,
    input logic              advanced,
    input play_mode_e        mode
  );
    logic [BPOS_W-1:0] b;
    b = advanced ? bp + BPOS_HALF : bp;
    return (mode == PLAY_DELTA) ? b - 4'd4 : b - 4'd8;
  endfunction

endpackage

// File: rtl/vox_phase.sv
module vox_phase #(
  parameter int PITCH_W = 12,
  parameter int INC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               run_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [INC_W-1:0]   inc_i,
  output logic               step_o,
  output logic [PITCH_W:0]   cnt_o
);

  localparam int CNT_W = PITCH_W + 1;
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] THRESH  = SUM_W'(1) << PITCH_W;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;

  function automatic logic [SUM_W-1:0] phase_add(
    input logic [CNT_W-1:0] c,
    input logic [INC_W-1:0] inc
  );
    return SUM_W'(c) + SUM_W'(inc);
  endfunction

  function automatic logic [CNT_W-1:0] phase_reload(
    input logic [SUM_W-1:0]   s,
    input logic [PITCH_W-1:0] p
  );
    logic [SUM_W-1:0] r;
    r = s - THRESH + SUM_W'(p);
    return (r > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : r[CNT_W-1:0];
  endfunction

  always_comb begin
    sum    = phase_add(cnt_q, inc_i);
    step_o = run_i && (sum >= THRESH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(pitch_i);
    end else if (run_i) begin
      cnt_q <= step_o ? phase_reload(sum, pitch_i) : sum[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;

  // R3: key-on seeds the counter with the pitch
  assert_load_pitch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_o == CNT_W'($past(pitch_i))));

  // R3: without a step the counter simply accumulates
  assert_accumulate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && !step_o) |=>
      (SUM_W'(cnt_o) == SUM_W'($past(cnt_o)) + SUM_W'($past(inc_i))));

endmodule

// File: rtl/vox_seq.sv
module vox_seq
  import vox_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_on_i,
  input  logic              key_off_i,
  input  logic              step_i,
  input  logic              reverse_i,
  input  logic              loop_i,
  input  play_mode_e        mode_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LEN_W-1:0]  length_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              active_o,
  output logic              hi_nib_o,
  output logic              restart_o,
  output logic              finish_o
);

  logic              en_q, busy_q;
  logic [ADDR_W-1:0] addr_q, moved, next_addr;
  logic [LEN_W-1:0]  rem_q;
  logic [BPOS_W-1:0] bp_q, bp_next;
  logic              adv, end_hit;

  always_comb begin
    adv          = step_i && (bp_q < BPOS_HALF);
    moved        = reverse_i ? addr_q - 1'b1 : addr_q + 1'b1;
    end_hit      = adv && (rem_q == '0);
    restart_o    = end_hit && loop_i;
    finish_o     = end_hit && !loop_i;
    next_addr    = restart_o ? start_i : (adv ? moved : addr_q);
    fetch_addr_o = step_i ? next_addr : addr_q;
    bp_next      = bpos_after(bp_q, adv, mode_i);
    hi_nib_o     = reverse_i ? ~bp_next[2] : bp_next[2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      bp_q   <= BPOS_START;
    end else if (key_on_i) begin
      en_q   <= 1'b1;
      busy_q <= 1'b1;
      addr_q <= start_i;
      rem_q  <= length_i;
      bp_q   <= BPOS_START;
    end else if (key_off_i) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
    end else if (step_i) begin
      addr_q <= next_addr;
      bp_q   <= bp_next;
      if (restart_o) begin
        rem_q <= length_i;
      end else if (adv && !end_hit) begin
        rem_q <= rem_q - 1'b1;
      end
      if (finish_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign active_o = en_q && busy_q;

  // R2: key-on starts playback at the start position
  assert_keyon_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_on_i |=> (active_o && addr_q == $past(start_i)));

  // R2: key-off alone stops playback
  assert_keyoff_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_off_i && !key_on_i) |=> !active_o);

  // R2: busy never outlives enable
  assert_busy_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> en_q);

  // R7: a one-shot pass ends playback
  assert_oneshot_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_o && !key_on_i && !key_off_i) |=> !active_o);

  // R7: a looping pass returns to the start position with a fresh count
  assert_loop_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o && !key_on_i && !key_off_i) |=>
      (addr_q == $past(start_i) && rem_q == $past(length_i) && active_o));

endmodule

// File: rtl/vox_delta.sv
module vox_delta
  import vox_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    restart_i,
  input  logic                    fire_i,
  input  play_mode_e              mode_i,
  input  logic                    hi_i,
  input  logic [BYTE_W-1:0]       byte_i,
  output logic signed [ACC_W-1:0] acc_o
);

  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, base;
  logic [NIB_W-1:0]        nib;

  // Positive codes grow upward from one, negative codes shrink toward -1.
  function automatic logic signed [ACC_W-1:0] code_value(input logic [NIB_W-1:0] c);
    logic [ACC_W-1:0] mag;
    if (c == '0) begin
      return '0;
    end else if (!c[3]) begin
      mag = ACC_W'(1) << (c[2:0] - 3'd1);
      return $signed(mag);
    end else begin
      mag = ACC_W'(1) << (~c[2:0]);
      return -$signed(mag);
    end
  endfunction

  function automatic logic signed [ACC_W-1:0] sat_add(
    input logic signed [ACC_W-1:0] a,
    input logic signed [ACC_W-1:0] b
  );
    logic signed [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if (s[ACC_W] != s[ACC_W-1]) begin
      return s[ACC_W] ? ACC_MIN : ACC_MAX;
    end
    return s[ACC_W-1:0];
  endfunction

  always_comb begin
    nib  = hi_i ? byte_i[7:4] : byte_i[3:0];
    base = restart_i ? '0 : acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
    end else if (fire_i) begin
      if (mode_i == PLAY_DELTA) begin
        acc_q <= (nib == '0) ? base : sat_add(base, code_value(nib));
      end else if (restart_i) begin
        acc_q <= '0;
      end
    end
  end

  assign acc_o = acc_q;

  // R6: a zero code leaves the running value alone
  assert_zero_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && mode_i == PLAY_DELTA && nib == '0 && !restart_i && !clear_i)
      |=> (acc_o == $past(acc_o)));

  // R6: at the positive limit a non-negative code cannot wrap the value
  assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o == ACC_MAX && fire_i && mode_i == PLAY_DELTA && !nib[3] &&
     !restart_i && !clear_i) |=> (acc_o == ACC_MAX));

  // R7: a loop restart drops the old running value
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && restart_i && nib == '0 && !clear_i) |=> (acc_o == '0));

endmodule

// File: rtl/vox_voice.sv
module vox_voice
  import vox_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int LEN_W   = 16,
  parameter int PITCH_W = 12,
  parameter int INC_W   = 8,
  parameter int VOL_W   = 7,
  parameter int ACC_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          key_on,
  input  logic                          key_off,
  input  logic [PITCH_W-1:0]            pitch,
  input  logic [LEN_W-1:0]              length,
  input  logic [ADDR_W-1:0]             start_addr,
  input  logic [VOL_W-1:0]              volume,
  input  logic                          loop_en,
  input  logic                          delta_mode,
  input  logic                          reverse,
  input  logic [INC_W-1:0]              cyc_inc,
  output logic [ADDR_W-1:0]             mem_addr,
  input  logic [BYTE_W-1:0]             mem_data,
  output logic signed [ACC_W+VOL_W-1:0] sample,
  output logic                          busy
);

  localparam int OUT_W  = ACC_W + VOL_W;
  localparam int PROD_W = OUT_W + 1;

  play_mode_e              mode;
  logic                    active, run, step;
  logic                    hi_nib, restart, finish;
  logic [PITCH_W:0]        phase_cnt;
  logic [BYTE_W-1:0]       data_q;
  logic signed [ACC_W-1:0] acc, source;
  logic signed [PROD_W-1:0] prod;

  assign mode = delta_mode ? PLAY_DELTA : PLAY_PCM;
  assign run  = active && !key_on && !key_off;

  vox_phase #(.PITCH_W(PITCH_W), .INC_W(INC_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (key_on),
    .run_i   (run),
    .pitch_i (pitch),
    .inc_i   (cyc_inc),
    .step_o  (step),
    .cnt_o   (phase_cnt)
  );

  vox_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_on_i     (key_on),
    .key_off_i    (key_off),
    .step_i       (step),
    .reverse_i    (reverse),
    .loop_i       (loop_en),
    .mode_i       (mode),
    .start_i      (start_addr),
    .length_i     (length),
    .fetch_addr_o (mem_addr),
    .active_o     (active),
    .hi_nib_o     (hi_nib),
    .restart_o    (restart),
    .finish_o     (finish)
  );

  vox_delta #(.ACC_W(ACC_W)) u_delta (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (key_on),
    .restart_i (restart),
    .fire_i    (step),
    .mode_i    (mode),
    .hi_i      (hi_nib),
    .byte_i    (mem_data),
    .acc_o     (acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (key_on) begin
      data_q <= '0;
    end else if (step) begin
      data_q <= mem_data;
    end
  end

  function automatic logic signed [ACC_W-1:0] widen_byte(input logic [BYTE_W-1:0] b);
    return {{(ACC_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic signed [PROD_W-1:0] apply_gain(
    input logic signed [ACC_W-1:0] v,
    input logic [VOL_W-1:0]        g
  );
    logic signed [PROD_W-1:0] wv, wg;
    wv = PROD_W'(v);
    wg = $signed(PROD_W'(g));
    return wv * wg;
  endfunction

  always_comb begin
    source = (mode == PLAY_DELTA) ? acc : widen_byte(data_q);
    prod   = apply_gain(source, volume);
    sample = active ? prod[OUT_W-1:0] : '0;
  end

  assign busy = active;

  // R4: the byte presented at a step is the one kept
  assert_byte_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !key_on) |=> (data_q == $past(mem_data)));

  // R2: nothing is audible right after key-on
  assert_keyon_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |=> (sample == '0));

  // R8: an idle voice is silent
  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sample == '0));

endmodule

// File: tb/vox_voice_bench.sv
`timescale 1ns/1ps
module vox_voice_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        key_on, key_off;
  logic [11:0] pitch;
  logic [15:0] length;
  logic [20:0] start_addr;
  logic [6:0]  volume;
  logic        loop_en, delta_mode, reverse;
  logic [7:0]  cyc_inc;
  logic [20:0] mem_addr;
  logic [7:0]  mem_data;
  logic signed [22:0] sample;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int mem_mode = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  vox_voice u_vox_voice (
    .clk(clk), .rst_n(rst_n), .key_on(key_on), .key_off(key_off),
    .pitch(pitch), .length(length), .start_addr(start_addr), .volume(volume),
    .loop_en(loop_en), .delta_mode(delta_mode), .reverse(reverse),
    .cyc_inc(cyc_inc), .mem_addr(mem_addr), .mem_data(mem_data),
    .sample(sample), .busy(busy)
  );

  // Behavioural sample memory: a hash of the address, or fixed patterns.
  function automatic logic [7:0] mem_fn(input logic [20:0] a);
    case (mem_mode)
      1: return 8'h77;
      2: return 8'h88;
      3: return 8'h07;
      default: return 8'((a * 113) ^ (a >> 5) ^ 21'h5A);
    endcase
  endfunction
  assign mem_data = mem_fn(mem_addr);

  // Reference state
  int m_en, m_busy, m_cnt, m_rem, m_bp, m_acc;
  logic [20:0] m_addr;
  logic [7:0]  m_data;

  function automatic int code_tab(input int n);
    int v = 1;
    if (n == 0) return 0;
    if (n < 8) begin
      for (int k = 1; k < n; k++) v = v * 2;
      return v;
    end
    for (int k = n; k < 15; k++) v = v * 2;
    return -v;
  endfunction

  function automatic int clamp16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int exp_sample();
    int src;
    if (!(m_en != 0 && m_busy != 0)) return 0;
    src = delta_mode ? m_acc : int'($signed(m_data));
    return src * int'(volume);
  endfunction

  task automatic check(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_busy = 0; m_cnt = 0; m_rem = 0; m_bp = 4; m_acc = 0;
    m_addr = '0; m_data = '0;
  endtask

  // Advance the reference by one edge with the inputs now driven.
  task automatic model_next(input bit kon, input bit koff);
    int s, nib, off;
    bit stepped = 0;
    if (kon) begin
      m_en = 1; m_busy = 1; m_cnt = pitch; m_addr = start_addr;
      m_rem = length; m_bp = 4; m_data = 0; m_acc = 0;
    end else if (koff) begin
      m_en = 0; m_busy = 0;
    end else if (m_en != 0 && m_busy != 0) begin
      s = m_cnt + cyc_inc;
      if (s >= 4096) begin
        stepped = 1;
        if (m_bp < 8) begin
          m_bp += 8;
          m_addr = reverse ? m_addr - 21'd1 : m_addr + 21'd1;
          m_rem -= 1;
          if (m_rem < 0) begin
            if (loop_en) begin
              m_addr = start_addr; m_rem = length; m_acc = 0;
            end else begin
              m_busy = 0;
            end
          end
        end
        m_data = mem_fn(m_addr);
        if (delta_mode) begin
          m_bp -= 4;
          off = reverse ? ((~m_bp) & 4) : (m_bp & 4);
          nib = (m_data >> off) & 15;
          if (nib != 0) m_acc = clamp16(m_acc + code_tab(nib));
        end else begin
          m_bp -= 8;
        end
        m_cnt = s - 4096 + pitch;
        if (m_cnt > 8191) m_cnt = 8191;
      end else begin
        m_cnt = s;
      end
    end
    if (stepped) check("mem_addr", mem_addr, m_addr);
  endtask

  // Called between a falling edge and the next rising edge.
  task automatic cyc(input bit kon = 0, input bit koff = 0);
    key_on = kon; key_off = koff;
    #0.2;
    model_next(kon, koff);
    @(negedge clk);
    check("busy", busy, m_busy != 0 && m_en != 0);
    check("sample", sample, exp_sample());
    key_on = 0; key_off = 0;
    #0.5;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic setup(input logic [11:0] p, input logic [7:0] ci, input logic [15:0] len,
                       input logic [20:0] st, input logic [6:0] vol,
                       input bit lp, input bit dm, input bit rv);
    pitch = p; cyc_inc = ci; length = len; start_addr = st; volume = vol;
    loop_en = lp; delta_mode = dm; reverse = rv;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; key_on = 0; key_off = 0;
    setup(12'h0, 8'h0, 16'h0, 21'h0, 7'h0, 0, 0, 0);
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    #0.5;
    tag = "R1";
    check("reset busy", busy, 0);
    check("reset sample", sample, 0);
    run(3);

    // R2: key-on, key-off and simultaneous pulses
    tag = "R2";
    setup(12'hE00, 8'h40, 16'd20, 21'h100, 7'd50, 0, 0, 0);
    cyc(1, 0);
    check("busy after key-on", busy, 1);
    check("silent after key-on", sample, 0);
    run(40);
    cyc(0, 1);
    check("busy after key-off", busy, 0);
    run(5);
    cyc(1, 1);
    check("key-on wins", busy, 1);
    run(10);

    // R4 / R8: PCM forward one-shot at full volume
    tag = "R4";
    setup(12'hE00, 8'h40, 16'd3, 21'h200, 7'd127, 0, 0, 0);
    cyc(1, 0);
    run(60);
    tag = "R8";
    check("idle after one-shot pass", busy, 0);
    setup(12'hF00, 8'h80, 16'd30, 21'h345, 7'd0, 1, 0, 0);
    cyc(1, 0);
    run(30);

    // R9 / R7: reverse loop across address zero, forward loop across the top
    tag = "R9";
    setup(12'hE00, 8'h40, 16'd3, 21'h1, 7'd9, 1, 0, 1);
    cyc(1, 0);
    run(80);
    setup(12'hE00, 8'h40, 16'd3, 21'h1FFFFE, 7'd9, 1, 0, 0);
    cyc(1, 0);
    run(80);

    // R5: delta forward and reverse nibble order
    tag = "R5";
    setup(12'hF00, 8'h80, 16'd2, 21'h40, 7'd3, 1, 1, 0);
    cyc(1, 0);
    run(60);
    setup(12'hF00, 8'h80, 16'd2, 21'h40, 7'd3, 1, 1, 1);
    cyc(1, 0);
    run(60);

    // R6: zero codes, positive and negative saturation
    tag = "R6";
    mem_mode = 3;
    setup(12'hF00, 8'h80, 16'd100, 21'h10, 7'd1, 0, 1, 0);
    cyc(1, 0);
    run(30);
    mem_mode = 1;
    setup(12'hFFF, 8'hFF, 16'hFFFF, 21'h10, 7'd1, 0, 1, 0);
    cyc(1, 0);
    run(700);
    check("positive limit", sample, 32767);
    mem_mode = 2;
    cyc(1, 0);
    run(400);
    check("negative limit", sample, -32768);
    mem_mode = 0;

    // R7: one-shot end in delta mode, loop restart in delta mode
    tag = "R7";
    setup(12'hF00, 8'h80, 16'd1, 21'h500, 7'd5, 0, 1, 0);
    cyc(1, 0);
    run(40);
    check("one-shot delta ended", busy, 0);
    setup(12'hF00, 8'h80, 16'd1, 21'h500, 7'd5, 1, 1, 1);
    cyc(1, 0);
    run(60);

    // R3: slowest rate, one step per 4096 clocks
    tag = "R3";
    setup(12'h000, 8'h01, 16'd5, 21'h900, 7'd11, 1, 0, 0);
    cyc(1, 0);
    run(9000);

    // Random configurations mixed with occasional key-off
    for (int r = 0; r < 30; r++) begin
      tag = (r % 2 == 0) ? "R4" : "R7";
      setup(12'($urandom_range(12'hA00, 12'hFFF)), 8'($urandom_range(1, 255)),
            16'($urandom_range(0, 6)), 21'($urandom), 7'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
      if (r % 5 == 4) start_addr = 21'($urandom_range(0, 2));
      cyc(1, 0);
      for (int i = 0; i < 200; i++) cyc(0, ($urandom_range(0, 150) == 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule